// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of three oscillators feeds the system clock: the primary oscillator, an internal RC oscillator, or a slow secondary oscillator. Software writes a 2-bit source code. The block resolves that code against the secondary-oscillator enable. If the resolved code differs from the current one, a switch starts. During the switch the core's four-phase sequencer is held in its first phase until eight falling edges of the newly selected source have been counted. When the count completes, the sequencer is released and the status flags are updated.

The external clock multiplexer provides a sampled copy of the newly selected source, `src_clk_i`. The block synchronises that input into the fast reference clock domain and counts its falling edges there. The block also drives the power-down request for the primary oscillator.

Top module: `clksw_ctrl`

## Requirements
- R1: On reset the following values hold: `sel_o`=00, `hold_q1_o`=0, `busy_o`=0, `osts_o`=1, `sec_run_o`=0 and `pri_pd_o`=0.
- R2: The source codes are 00 for the primary source set by the oscillator configuration field, 10 for the internal RC oscillator, and 01 or 11 for the secondary oscillator. When `sec_en_i`=1, an accepted write's resolved code equals the written code. A switch starts only if the resolved code differs from `sel_o`; otherwise nothing changes.
- R3: When `sec_en_i`=0, bit 0 of the written code is forced to 0 before the comparison. For example, 00 written with 11 gives 10, and 10 written with 01 gives 00.
- R4: `hold_q1_o` and `busy_o` rise one cycle after a write that starts a switch. `src_clk_i` passes through a two-flop synchroniser. A falling edge is a synchronised 1 followed by a synchronised 0. Both outputs fall at the clock edge that registers the eighth such falling edge after the start.
- R5: A write that arrives while `busy_o`=1 is ignored. This includes the cycle in which the eighth edge is counted.
- R6: `osts_o` clears when a switch to a secondary code (x1) starts. It sets when a switch to a non-secondary code completes.
- R7: `sec_run_o` becomes 1 when a switch to a secondary code completes. It becomes 0 when a switch to any other code completes.
- R8: `pri_pd_o` rises when a switch to a secondary code starts. It falls when a switch to a non-secondary code completes.
- R9: Falling edges seen while the block is not switching are not counted. Every switch counts eight fresh edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_wr_i | input | 1 | Source-code write strobe |
| sel_wdata_i | input | 2 | Written source code |
| sec_en_i | input | 1 | Secondary oscillator enable |
| src_clk_i | input | 1 | Sampled level of the newly selected source |
| sel_o | output | 2 | Current resolved source code |
| hold_q1_o | output | 1 | Holds the phase sequencer in its first phase |
| busy_o | output | 1 | A switch is in progress |
| osts_o | output | 1 | Oscillator start-up status |
| sec_run_o | output | 1 | Secondary oscillator is the system clock |
| pri_pd_o | output | 1 | Power-down request for the primary oscillator |

## Verification
Two functions can fall in the same cycle: completion of a switch on its eighth edge, and acceptance of a new source write. The bench provokes the overlap by holding the write strobe high with changing codes across whole switches, so that one write lands exactly on the completing edge. The per-cycle reference model decides the outcome. The write in the completing cycle must be dropped, and the status flags must follow only the completed switch.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_PRI = 2'b00;
  localparam sel_t SEL_RC  = 2'b10;
endpackage

// File: rtl/clksw_resolve.sv
module clksw_resolve
  import clksw_pkg::*;
(
  input  sel_t wdata_i,
  input  logic sec_en_i,
  output sel_t final_o
);
  // secondary codes (x1) fall back to their even neighbour when disabled
  always_comb begin
    final_o    = wdata_i;
    final_o[0] = wdata_i[0] & sec_en_i;
  end
endmodule

// File: rtl/clksw_fall_det.sv
module clksw_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], src_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/clksw_edge_cnt.sv
module clksw_edge_cnt #(
  parameter int EDGES = 8,
  localparam int CW = $clog2(EDGES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fall_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q & fall_i & (cnt_q == CW'(EDGES - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && fall_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
    end
  end

  a_r4_release_at_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> cnt_q == CW'(EDGES));
  a_r9_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int HOLD_EDGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_wr_i,
  input  logic [1:0] sel_wdata_i,
  input  logic       sec_en_i,
  input  logic       src_clk_i,
  output logic [1:0] sel_o,
  output logic       hold_q1_o,
  output logic       busy_o,
  output logic       osts_o,
  output logic       sec_run_o,
  output logic       pri_pd_o
);
  sel_t sel_q, final_sel;
  logic fall, busy, done, start;
  logic osts_q, sec_run_q, pri_pd_q;

  clksw_resolve u_resolve (
    .wdata_i (sel_wdata_i),
    .sec_en_i(sec_en_i),
    .final_o (final_sel)
  );

  clksw_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_clk_i),
    .fall_o(fall)
  );

  clksw_edge_cnt #(.EDGES(HOLD_EDGES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .fall_i (fall),
    .busy_o (busy),
    .done_o (done)
  );

  assign start = sel_wr_i & ~busy & (final_sel != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= SEL_PRI;
      osts_q    <= 1'b1;
      sec_run_q <= 1'b0;
      pri_pd_q  <= 1'b0;
    end else if (start) begin
      sel_q <= final_sel;
      if (final_sel[0]) begin
        osts_q   <= 1'b0;
        pri_pd_q <= 1'b1;
      end
    end else if (done) begin
      sec_run_q <= sel_q[0];
      if (!sel_q[0]) begin
        osts_q   <= 1'b1;
        pri_pd_q <= 1'b0;
      end
    end
  end

  assign sel_o     = sel_q;
  assign hold_q1_o = busy;
  assign busy_o    = busy;
  assign osts_o    = osts_q;
  assign sec_run_o = sec_run_q;
  assign pri_pd_o  = pri_pd_q;

  a_r2_same_code_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !busy && final_sel == sel_q) |=> !busy && $stable(sel_q));
  a_r3_remap_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !sec_en_i) |=> (!sel_q[0] || $stable(sel_q)));
  a_r5_busy_ignores_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(sel_q));
  a_r6_osts_low_on_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sel_q[0]) |-> !osts_q);
  a_r7_sec_run_after_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_run_q) |-> $past(busy) && sel_q[0]);
  a_r8_pd_with_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_run_q && !busy) |-> pri_pd_q);
endmodule

// File: tb/clksw_ctrl_tb.sv
`timescale 1ns/1ps
module clksw_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic wr = 0, en = 1, src = 0;
  logic [1:0] wd = 0;
  logic [1:0] sel;
  logic hold, busy, osts, srun, pd;
  int n_chk = 0, n_fail = 0;
  int half = 3, ph = 0;

  always #2.5 clk = ~clk;

  clksw_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_wr_i(wr), .sel_wdata_i(wd),
    .sec_en_i(en), .src_clk_i(src), .sel_o(sel), .hold_q1_o(hold),
    .busy_o(busy), .osts_o(osts), .sec_run_o(srun), .pri_pd_o(pd)
  );

  // behavioural reference model
  int m_sel = 0, m_busy = 0, m_edges = 0, m_osts = 1, m_run = 0, m_pd = 0;
  bit d1 = 0, d2 = 0, d3 = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_busy = 0; m_edges = 0; m_osts = 1; m_run = 0; m_pd = 0;
      d1 = 0; d2 = 0; d3 = 0;
    end else begin
      bit f;
      int fin;
      f = d3 && !d2;
      fin = (wd & 2) | ((wd & 1) & int'(en));
      if (m_busy != 0) begin
        if (f) begin
          m_edges++;
          if (m_edges == 8) begin
            m_busy = 0;
            m_run = m_sel & 1;
            if ((m_sel & 1) == 0) begin m_osts = 1; m_pd = 0; end
          end
        end
      end else if (wr && fin != m_sel) begin
        m_sel = fin; m_busy = 1; m_edges = 0;
        if ((fin & 1) != 0) begin m_osts = 0; m_pd = 1; end
      end
      d3 = d2; d2 = d1; d1 = src;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2/R3 sel", sel, m_sel);
    chk("R4 busy", busy, m_busy);
    chk("R4 hold", hold, m_busy);
    chk("R6 osts", osts, m_osts);
    chk("R7 sec_run", srun, m_run);
    chk("R8 pri_pd", pd, m_pd);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ph++;
      if (ph >= half) begin src = ~src; ph = 0; end
    end
  endtask

  task automatic write(input logic [1:0] c);
    @(negedge clk); wr = 1; wd = c;
    step(1);
    wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) step(1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset values
    chk("R1 sel", sel, 0); chk("R1 hold", hold, 0); chk("R1 busy", busy, 0);
    chk("R1 osts", osts, 1); chk("R1 sec_run", srun, 0); chk("R1 pri_pd", pd, 0);
    rst_n = 1;
    step(20);                       // R9 idle edges must not count
    write(2'b00); step(5);          // R2 same code: no event
    chk("R2 no event", busy, 0);
    write(2'b01); step(2);          // R6/R8 switch to secondary
    wait_idle(); step(3);
    chk("R7 sec_run set", srun, 1);
    half = 1;
    write(2'b10); step(3);          // R5 write while busy
    write(2'b00); step(1);
    chk("R5 ignored", sel, 2);
    wait_idle(); step(3);
    en = 0;
    write(2'b11); step(3);          // R3 10 + 11 -> stays 10
    chk("R3 10/11", sel, 2);
    write(2'b01); wait_idle(); step(2); // R3 10 + 01 -> 00
    chk("R3 10/01", sel, 0);
    write(2'b11); wait_idle(); step(2); // R3 00 + 11 -> 10
    chk("R3 00/11", sel, 2);
    en = 1;
    half = 2;
    // R5 overlap: strobe held with changing codes across completions
    for (int k = 0; k < 120; k++) begin
      @(negedge clk); wr = 1; wd = 2'(k);
      step(1);
    end
    wr = 0;
    wait_idle(); step(5);
    half = 5;
    write(2'b11); wait_idle(); step(3);
    write(2'b00); wait_idle(); step(3);
    chk("R8 pd clear", pd, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule